// File: doc/BRIEF.md
# Two-Stage Priority Request Arbiter

This block chooses one winner among a set of stream request lines that compete for a single bus master port. Every stream has a two-bit priority level supplied at run time through a configuration input. A stream can only win if its request line and its enable bit are both high. The winner is the eligible stream with the highest level. When several eligible streams share that level, the one with the smallest index wins.

The grant is registered. It stays on the same stream until the transfer completes, and completion is signalled by a one-cycle pulse on the done input. The arbiter then spends one cycle with no grant and picks the next winner from the inputs present on that cycle. A system with two bus master ports places one instance in front of each port. The bus protocol and the data movement stay outside the block.

Top module: `stream_prio_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `gnt_o` is all zeros and `gnt_vld_o` is low.
- R2: A stream whose `en_i` bit is low is never granted, even when its `req_i` bit is high.
- R3: Stream i takes its level from `lvl_cfg_i[2i+1:2i]`. The encoding is 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. A stream with a higher level beats any eligible stream with a lower level, whatever their indices.
- R4: When eligible streams have the same level, the lowest index wins. For example, stream 2 beats stream 4.
- R5: While `gnt_vld_o` is high, `gnt_o` has exactly one bit set, at the granted stream's index. While it is low, `gnt_o` is zero.
- R6: While no grant is held, an eligible request seen at a clock edge produces a grant visible right after that edge.
- R7: A held grant keeps the same `gnt_o` and a high `gnt_vld_o` until `done_i` is sampled high. Changes to requests, enables or levels during that time do not affect it.
- R8: The edge that samples `done_i` high clears the grant. The next winner is chosen at the following edge, from the inputs present on that cycle.
- R9: If no stream is eligible, `gnt_vld_o` stays low and `gnt_o` stays zero.
- R10: `done_i` has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_REQ | Request line per stream |
| en_i | input | NUM_REQ | Enable bit per stream |
| lvl_cfg_i | input | NUM_REQ*LVL_W | Priority level per stream, packed by index |
| done_i | input | 1 | One-cycle pulse at the end of the current transfer |
| gnt_o | output | NUM_REQ | One-hot grant |
| gnt_vld_o | output | 1 | A grant is held |

## Verification
There is one registered stage between the inputs and the grant, so an arbitration result is due one clock edge after its inputs. A release takes two edges: `gnt_vld_o` is low one edge after `done_i` is sampled high, and the next winner appears one edge after that. The bench drives every input on the falling edge and reads the outputs on the following falling edge. That places each check exactly one rising edge after its stimulus, and the release scenario counts its two edges explicitly. During a held grant the bench checks the outputs on several consecutive cycles while levels, enables and requests change, which confirms that those changes are ignored.

// File: rtl/spa_pkg.sv
// Package: shared types for the stream priority arbiter.
// Assumes nothing beyond a single clock domain.
package spa_pkg;
    // Grant-holding state.
    typedef enum logic {
        SPA_IDLE = 1'b0,
        SPA_BUSY = 1'b1
    } spa_state_t;
endpackage

// File: rtl/spa_eligible.sv
// Module: spa_eligible
// Marks each stream eligible when its request and enable are both high.
// Assumes req_i and en_i are synchronous to the arbiter clock.
module spa_eligible #(
    parameter int NUM_REQ = 8
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [NUM_REQ-1:0] en_i,
    output logic [NUM_REQ-1:0] elig_o
);
    // One gate per stream; generate keeps the structure explicit.
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_mask
        assign elig_o[g] = req_i[g] & en_i[g];
    end
endmodule

// File: rtl/spa_level_tree.sv
// Module: spa_level_tree
// Binary comparison tree that picks the eligible stream with the highest
// level. On equal levels the left (lower index) child wins.
// Assumes levels are unsigned, with a larger value meaning higher priority.
module spa_level_tree #(
    parameter int NUM_REQ = 8,
    parameter int LVL_W   = 2
) (
    input  logic [NUM_REQ-1:0]       elig_i,
    input  logic [NUM_REQ*LVL_W-1:0] lvl_cfg_i,
    output logic                     win_vld_o,
    output logic [((NUM_REQ > 1) ? $clog2(NUM_REQ) : 1)-1:0] win_idx_o
);
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES;

    // Heap-ordered nodes: leaves sit at LEAVES..NODES-1 and node 1 is the root.
    logic             node_vld [NODES];
    logic [LVL_W-1:0] node_lvl [NODES];
    logic [IDX_W-1:0] node_idx [NODES];

    // Node 0 is unused; tie it off.
    assign node_vld[0] = 1'b0;
    assign node_lvl[0] = '0;
    assign node_idx[0] = '0;

    // Leaves: real streams carry their inputs, padding leaves are never valid.
    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        if (g < NUM_REQ) begin : g_real
            assign node_vld[LEAVES+g] = elig_i[g];
            assign node_lvl[LEAVES+g] = lvl_cfg_i[g*LVL_W +: LVL_W];
            assign node_idx[LEAVES+g] = IDX_W'(g);
        end else begin : g_pad
            assign node_vld[LEAVES+g] = 1'b0;
            assign node_lvl[LEAVES+g] = '0;
            assign node_idx[LEAVES+g] = '0;
        end
    end

    // Internal nodes: the left child wins on ties, which gives lowest-index order.
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic left_wins;
        assign left_wins   = node_vld[2*n] &&
                             (!node_vld[2*n+1] || (node_lvl[2*n] >= node_lvl[2*n+1]));
        assign node_vld[n] = node_vld[2*n] | node_vld[2*n+1];
        assign node_lvl[n] = left_wins ? node_lvl[2*n] : node_lvl[2*n+1];
        assign node_idx[n] = left_wins ? node_idx[2*n] : node_idx[2*n+1];
    end

    assign win_vld_o = node_vld[1];
    assign win_idx_o = node_idx[1];
endmodule

// File: rtl/spa_grant_hold.sv
// Module: spa_grant_hold
// Captures the tree's winner as a one-hot grant while idle and holds it
// until done is sampled high. The cycle after a release is always idle.
// Assumes done_i is a single-cycle pulse aligned to the held transfer.
module spa_grant_hold
    import spa_pkg::*;
#(
    parameter int NUM_REQ = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_vld_i,
    input  logic [((NUM_REQ > 1) ? $clog2(NUM_REQ) : 1)-1:0] win_idx_i,
    input  logic                done_i,
    output logic [NUM_REQ-1:0]  gnt_o,
    output logic                gnt_vld_o
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    spa_state_t         state_q;
    logic [NUM_REQ-1:0] gnt_q;
    logic [NUM_REQ-1:0] win_onehot;

    // Decode the winning index into a one-hot vector.
    always_comb begin
        for (int i = 0; i < NUM_REQ; i++) begin
            win_onehot[i] = win_vld_i && (win_idx_i == IDX_W'(i));
        end
    end

    // Grant register: capture when idle, release on done when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SPA_IDLE;
            gnt_q   <= '0;
        end else begin
            case (state_q)
                SPA_IDLE: begin
                    if (win_vld_i) begin
                        state_q <= SPA_BUSY;
                        gnt_q   <= win_onehot;
                    end
                end
                SPA_BUSY: begin
                    if (done_i) begin
                        state_q <= SPA_IDLE;
                        gnt_q   <= '0;
                    end
                end
                default: begin
                    state_q <= SPA_IDLE;
                    gnt_q   <= '0;
                end
            endcase
        end
    end

    assign gnt_o     = gnt_q;
    assign gnt_vld_o = (state_q == SPA_BUSY);
endmodule

// File: rtl/stream_prio_arbiter.sv
// Module: stream_prio_arbiter (top)
// Grants one bus master port to the eligible stream with the highest
// programmed level, with the lowest index breaking ties. The grant is held
// until done pulses. One instance serves one master port.
// Assumes synchronous active-low reset and single-clock inputs.
module stream_prio_arbiter #(
    parameter int NUM_REQ = 8,
    parameter int LVL_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req_i,
    input  logic [NUM_REQ-1:0]       en_i,
    input  logic [NUM_REQ*LVL_W-1:0] lvl_cfg_i,
    input  logic                     done_i,
    output logic [NUM_REQ-1:0]       gnt_o,
    output logic                     gnt_vld_o
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic [NUM_REQ-1:0] elig;
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;

    // Stage 1: mask requests with their enables.
    spa_eligible #(.NUM_REQ(NUM_REQ)) u_elig (
        .req_i  (req_i),
        .en_i   (en_i),
        .elig_o (elig)
    );

    // Stage 2: level comparison, with index order breaking ties.
    spa_level_tree #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_tree (
        .elig_i    (elig),
        .lvl_cfg_i (lvl_cfg_i),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx)
    );

    // Stage 3: grant capture and hold.
    spa_grant_hold #(.NUM_REQ(NUM_REQ)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_vld_i (win_vld),
        .win_idx_i (win_idx),
        .done_i    (done_i),
        .gnt_o     (gnt_o),
        .gnt_vld_o (gnt_vld_o)
    );
endmodule

// File: rtl/spa_checker.sv
// Module: spa_checker
// Temporal checks on the arbiter ports, bound into every instance.
module spa_checker #(
    parameter int NUM_REQ = 8,
    parameter int LVL_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_REQ-1:0]       req_i,
    input logic [NUM_REQ-1:0]       en_i,
    input logic [NUM_REQ*LVL_W-1:0] lvl_cfg_i,
    input logic                     done_i,
    input logic [NUM_REQ-1:0]       gnt_o,
    input logic                     gnt_vld_o
);
    // R1: first cycle after reset release shows no grant.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (gnt_o == '0 && !gnt_vld_o));

    // R2: a fresh grant goes only to a stream that was requesting and enabled.
    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_vld_o) |-> ((gnt_o & ~($past(req_i) & $past(en_i))) == '0));

    // R5: one-hot while valid.
    assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> ($countones(gnt_o) == 1));

    // R5: zero while not valid.
    assert_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld_o |-> (gnt_o == '0));

    // R6: eligible request while idle yields a grant next cycle.
    assert_grant_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld_o && |(req_i & en_i)) |=> gnt_vld_o);

    // R7: a held grant is stable until done.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && !done_i) |=> (gnt_vld_o && $stable(gnt_o)));

    // R8: done on a held grant clears it on the next cycle.
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && done_i) |=> !gnt_vld_o);

    // R9 and R10: with nothing eligible while idle, no grant appears, done or not.
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld_o && !(|(req_i & en_i))) |=> !gnt_vld_o);
endmodule

bind stream_prio_arbiter spa_checker #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_spa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .en_i      (en_i),
    .lvl_cfg_i (lvl_cfg_i),
    .done_i    (done_i),
    .gnt_o     (gnt_o),
    .gnt_vld_o (gnt_vld_o)
);

// File: tb/sim_stream_prio_arbiter.sv
// Directed bench: each task drives one scenario on the falling edge and
// checks the outputs one rising edge later.
module sim_stream_prio_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int LW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    req;
    logic [N-1:0]    en;
    logic [N*LW-1:0] cfg;
    logic            done;
    logic [N-1:0]    gnt;
    logic            gnt_vld;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_prio_arbiter #(.NUM_REQ(N), .LVL_W(LW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .en_i      (en),
        .lvl_cfg_i (cfg),
        .done_i    (done),
        .gnt_o     (gnt),
        .gnt_vld_o (gnt_vld)
    );

    // Expected winner as one-hot: highest level first, then lowest index.
    function automatic logic [N-1:0] model_win(logic [N-1:0] r, logic [N-1:0] e,
                                               logic [N*LW-1:0] c);
        logic [N-1:0] res = '0;
        for (int lv = 3; lv >= 0; lv--) begin
            for (int i = 0; i < N; i++) begin
                if (res == '0 && r[i] && e[i] && c[i*LW +: LW] == LW'(lv)) res[i] = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic logic [N*LW-1:0] set_lvl(logic [N*LW-1:0] c, int idx, logic [LW-1:0] v);
        logic [N*LW-1:0] t = c;
        t[idx*LW +: LW] = v;
        return t;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check both outputs against an expected one-hot grant.
    task automatic check_grant(string tag, logic [N-1:0] exp);
        check({tag, " gnt"}, 32'(gnt), 32'(exp));
        check({tag, " vld"}, 32'(gnt_vld), 32'(exp != '0));
    endtask

    // Drive inputs while idle and check the grant one edge later.
    task automatic arbitrate(string tag, logic [N-1:0] r, logic [N-1:0] e, logic [N*LW-1:0] c);
        @(negedge clk);
        req = r; en = e; cfg = c;
        @(negedge clk);
        check_grant(tag, model_win(r, e, c));
    endtask

    // Pulse done, drop requests, and confirm the grant is gone.
    task automatic release_grant(string tag);
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0; req = '0;
        check_grant(tag, '0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req = '1; en = '1; cfg = '1; done = 1'b0;
        repeat (3) @(negedge clk);
        check_grant("R1 during reset", '0);
        req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check_grant("R1 after release", '0);
    endtask

    task automatic t_none();
        arbitrate("R9 no requests", '0, '1, '1);
        arbitrate("R2 requests all disabled", '1, '0, '1);
        @(negedge clk);
        check_grant("R9 still idle", '0);
        req = '0;
    endtask

    task automatic t_level();
        logic [N*LW-1:0] c = '0;
        c = set_lvl(c, 7, 2'b11);
        arbitrate("R3 stream7 very high", '1, '1, c);
        check("R3 R5 stream7 onehot", 32'(gnt), 32'h80);
        release_grant("R8 release 7");
        c = '0;
        c = set_lvl(c, 5, 2'b10);
        c = set_lvl(c, 6, 2'b01);
        arbitrate("R3 high over medium", 8'b0110_0011, '1, c);
        release_grant("R8 release 5");
        c = {N{2'b01}};
        c = set_lvl(c, 3, 2'b00);
        arbitrate("R3 medium over low", 8'b1000_1000, '1, c);
        release_grant("R8 release 7b");
    endtask

    task automatic t_tie();
        logic [N*LW-1:0] c = '0;
        c = set_lvl(c, 2, 2'b10);
        c = set_lvl(c, 4, 2'b10);
        arbitrate("R4 stream2 beats stream4", 8'b0001_0100, '1, c);
        check("R4 stream2", 32'(gnt), 32'h04);
        release_grant("R8 release 2");
        arbitrate("R4 all equal lowest wins", 8'b1110_0000, '1, '0);
        release_grant("R8 release 5b");
    endtask

    task automatic t_disable();
        logic [N*LW-1:0] c = '0;
        c = set_lvl(c, 1, 2'b11);
        arbitrate("R2 disabled stream1 skipped", 8'b0100_0010, 8'b1111_1101, c);
        check("R2 winner stream6", 32'(gnt), 32'h40);
        release_grant("R8 release 6");
    endtask

    task automatic t_hold();
        logic [N*LW-1:0] c = {N{2'b01}};
        arbitrate("R6 grant stream3", 8'b0000_1000, '1, c);
        @(negedge clk);
        c = set_lvl(c, 0, 2'b11);
        cfg = c; req = 8'b0000_0001; en = 8'b1111_0111;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_grant("R7 held stream3", 8'h08);
        end
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check_grant("R8 gap cycle", '0);
        @(negedge clk);
        check_grant("R8 new winner stream0", 8'h01);
        release_grant("R8 release 0");
        en = '1;
    endtask

    task automatic t_done_idle();
        @(negedge clk);
        req = '0; done = 1'b1;
        repeat (2) @(negedge clk);
        check_grant("R10 done idle no grant", '0);
        req = 8'b0010_0000;
        @(negedge clk);
        check_grant("R10 grant despite done", 8'h20);
        req = '0;
        @(negedge clk);
        done = 1'b0;
        check_grant("R8 release with done", '0);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_none();
        t_level();
        t_tie();
        t_disable();
        t_hold();
        t_done_idle();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule